// File: doc/BRIEF.md
# Operand Address Resolver with Bit Read-Modify-Write

This block sits between the operand decode of a small accumulator-based controller and its internal memories. It takes one operand reference per request and turns it into a physical location: a target (lower/upper data RAM or the special function register space), an 8-bit byte address and a bit position. There are four kinds of operand. A register number is placed in the bank picked by the two bank-select bits. A direct byte address goes to RAM or to the register space. A pointer-indirect address always goes to RAM. A bit address is split into a byte address and a bit position.

The resolved location is registered, so it is ready one clock after the request. The memory returns the addressed byte on `rd_byte` in that same cycle. The block then forms the merged write byte and a byte-lane mask for a byte write or for a bit set, clear or write. It also returns the read data and the selected bit. An enable input can shut off the upper half of RAM: indirect accesses to that half then read as zero and their writes are dropped.

Top module: `operand_resolver`

## Requirements
- R1: A register operand (op_kind 0) with register number r in bank b (bank_sel) resolves to RAM (tgt_sfr 0) at byte address b*8 + r.
- R2: A bit operand (op_kind 3) with bit address 00h..7Fh resolves to RAM byte 20h + (bit address >> 3), with bit_idx equal to bit address[2:0].
- R3: A bit operand with bit address 80h..FFh resolves to the register space (tgt_sfr 1). The byte address is the bit address with bits [2:0] cleared, and bit_idx is bit address[2:0].
- R4: A direct operand (op_kind 1) with address 00h..7Fh resolves to RAM at that address. Address 80h..FFh resolves to the register space at that address.
- R5: An indirect operand (op_kind 2) always resolves to RAM at the given 8-bit address.
- R6: An indirect operand at 80h..FFh with upper_ram_en 0 raises access_blocked. It drives rd_data and bit_rd to 0 and wr_mask to 00h for every access kind. With upper_ram_en 1 the access proceeds normally.
- R7: A bit operand with acc_op 2 (set) or 3 (clear) gives a wr_mask with only bit bit_idx set. wr_data equals rd_byte with only that bit forced to 1 or 0.
- R8: A bit operand with acc_op 1 (write) puts wr_val[0] into bit bit_idx of rd_byte. With acc_op 0 (read) it drives bit_rd = rd_byte[bit_idx] and wr_mask 00h.
- R9: A byte operand (kinds 0..2) with acc_op 1 gives wr_mask FFh and wr_data = wr_val. With acc_op 0, 2 or 3 it gives wr_mask 00h, and rd_data follows rd_byte.
- R10: A request sampled with in_vld 1 at a clock edge gives out_vld 1 and its resolved outputs after that edge. When out_vld is 0, wr_mask is 00h.
- R11: While rst is high and after it falls, out_vld is 0 and wr_mask is 00h until a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Request strobe |
| op_kind | input | 2 | 0 register, 1 direct, 2 indirect, 3 bit |
| acc_op | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| reg_num | input | 3 | Register number within the bank |
| op_addr | input | 8 | Direct, indirect or bit address |
| bank_sel | input | 2 | Active register bank |
| upper_ram_en | input | 1 | Enables indirect access to RAM 80h..FFh |
| wr_val | input | 8 | Byte to write; bit 0 is the bit value for bit writes |
| rd_byte | input | 8 | Byte read from the resolved location |
| out_vld | output | 1 | Resolved outputs valid |
| tgt_sfr | output | 1 | 1 register space, 0 RAM |
| byte_addr | output | 8 | Resolved byte address |
| bit_idx | output | 3 | Resolved bit position |
| wr_mask | output | 8 | Byte lanes to write |
| wr_data | output | 8 | Merged byte to write |
| rd_data | output | 8 | Read byte (zero when blocked) |
| bit_rd | output | 1 | Selected bit of rd_data |
| access_blocked | output | 1 | Access hit disabled upper RAM |

## Verification
The bench builds the block with its default parameters: four banks of eight registers, a bit-addressable RAM window starting at 20h, and upper RAM present but gated by `upper_ram_en`. With these values the bench can reach every bank boundary, both ends of the linear bit window, aligned register-space bytes such as 80h, 88h, C8h and E0h, the 7Fh/80h split for direct addresses, and indirect access to upper RAM both enabled and disabled.

// File: rtl/opres_pkg.sv
package opres_pkg;

    typedef enum logic [1:0] {
        OPK_REG      = 2'd0,
        OPK_DIRECT   = 2'd1,
        OPK_INDIRECT = 2'd2,
        OPK_BIT      = 2'd3
    } opk_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_SET   = 2'd2,
        ACC_CLR   = 2'd3
    } acc_e;

    typedef enum logic {
        TGT_RAM = 1'b0,
        TGT_SFR = 1'b1
    } tgt_e;

    typedef struct packed {
        tgt_e       tgt;
        logic [7:0] addr;
        logic [2:0] idx;
    } loc_t;

    typedef struct packed {
        logic       vld;
        opk_e       kind;
        acc_e       op;
        loc_t       loc;
        logic       blocked;
        logic [7:0] wval;
    } req_t;

    localparam logic [7:0] SFR_ALIGN_MASK = 8'hF8;

    function automatic logic in_high_half(input logic [7:0] a);
        return a[7];
    endfunction

    function automatic logic [7:0] lane_of(input logic [2:0] idx);
        return 8'(1) << idx;
    endfunction

endpackage

// File: rtl/bank_reg_map.sv
module bank_reg_map
    import opres_pkg::*;
#(
    parameter int NUM_BANKS     = 4,
    parameter int REGS_PER_BANK = 8,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int REG_W  = (REGS_PER_BANK > 1) ? $clog2(REGS_PER_BANK) : 1
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [REG_W-1:0]  rnum,
    output loc_t              loc
);
    localparam bit POW2 = (REGS_PER_BANK == (1 << REG_W));

    logic [7:0] base_addr;

    generate
        if (POW2) begin : g_concat
            always_comb base_addr = 8'({bank, rnum});
        end else begin : g_mult
            always_comb base_addr = 8'(int'(bank) * REGS_PER_BANK + int'(rnum));
        end
    endgenerate

    always_comb begin
        loc.tgt  = TGT_RAM;
        loc.addr = base_addr;
        loc.idx  = 3'd0;
    end
endmodule

// File: rtl/bit_addr_map.sv
module bit_addr_map
    import opres_pkg::*;
#(
    parameter logic [7:0] BIT_RAM_BASE = 8'h20
) (
    input  logic [7:0] bit_addr,
    output loc_t       loc
);
    always_comb begin
        loc.idx = bit_addr[2:0];
        if (in_high_half(bit_addr)) begin
            loc.tgt  = TGT_SFR;
            loc.addr = bit_addr & SFR_ALIGN_MASK;
        end else begin
            loc.tgt  = TGT_RAM;
            loc.addr = BIT_RAM_BASE + 8'(bit_addr[6:3]);
        end
    end
endmodule

// File: rtl/byte_addr_map.sv
module byte_addr_map
    import opres_pkg::*;
#(
    parameter bit UPPER_RAM_PRESENT = 1'b1
) (
    input  logic [7:0] addr,
    input  logic       indirect,
    input  logic       upper_en,
    output loc_t       loc,
    output logic       blocked
);
    logic hi;
    always_comb hi = in_high_half(addr);

    always_comb begin
        loc.addr = addr;
        loc.idx  = 3'd0;
        loc.tgt  = (hi && !indirect) ? TGT_SFR : TGT_RAM;
    end

    generate
        if (UPPER_RAM_PRESENT) begin : g_upper
            always_comb blocked = indirect && hi && !upper_en;
        end else begin : g_no_upper
            logic unused_en;
            always_comb unused_en = upper_en;
            always_comb blocked = indirect && hi;
        end
    endgenerate
endmodule

// File: rtl/bit_rmw_unit.sv
module bit_rmw_unit
    import opres_pkg::*;
(
    input  req_t       req,
    input  logic [7:0] rd_byte,
    output logic [7:0] wr_mask,
    output logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       bit_rd
);
    logic       is_bit;
    logic [7:0] new_bits;

    always_comb begin
        is_bit = (req.kind == OPK_BIT);
        wr_mask = 8'h00;
        new_bits = req.wval;
        if (req.vld && !req.blocked) begin
            if (is_bit) begin
                if (req.op != ACC_READ) wr_mask = lane_of(req.loc.idx);
                case (req.op)
                    ACC_SET:   new_bits = 8'hFF;
                    ACC_CLR:   new_bits = 8'h00;
                    default:   new_bits = {8{req.wval[0]}};
                endcase
            end else if (req.op == ACC_WRITE) begin
                wr_mask = 8'hFF;
            end
        end
        rd_data = req.blocked ? 8'h00 : rd_byte;
        bit_rd  = rd_data[req.loc.idx];
        wr_data = (rd_byte & ~wr_mask) | (new_bits & wr_mask);
    end
endmodule

// File: rtl/operand_resolver.sv
module operand_resolver
    import opres_pkg::*;
#(
    parameter int         NUM_BANKS         = 4,
    parameter int         REGS_PER_BANK     = 8,
    parameter logic [7:0] BIT_RAM_BASE      = 8'h20,
    parameter bit         UPPER_RAM_PRESENT = 1'b1,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int REG_W  = (REGS_PER_BANK > 1) ? $clog2(REGS_PER_BANK) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [1:0]        op_kind,
    input  logic [1:0]        acc_op,
    input  logic [REG_W-1:0]  reg_num,
    input  logic [7:0]        op_addr,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic              upper_ram_en,
    input  logic [7:0]        wr_val,
    input  logic [7:0]        rd_byte,
    output logic              out_vld,
    output logic              tgt_sfr,
    output logic [7:0]        byte_addr,
    output logic [2:0]        bit_idx,
    output logic [7:0]        wr_mask,
    output logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic              bit_rd,
    output logic              access_blocked
);
    localparam int BANK_TOP = NUM_BANKS * REGS_PER_BANK;
    localparam logic [7:0] BIT_RAM_LAST = BIT_RAM_BASE + 8'd15;

    opk_e kind_in;
    acc_e op_in;
    loc_t loc_reg, loc_bit, loc_byte, loc_sel;
    logic byte_blocked;
    req_t req_d, req_q;

    always_comb begin
        kind_in = opk_e'(op_kind);
        op_in   = acc_e'(acc_op);
    end

    bank_reg_map #(.NUM_BANKS(NUM_BANKS), .REGS_PER_BANK(REGS_PER_BANK)) u_bank (
        .bank (bank_sel),
        .rnum (reg_num),
        .loc  (loc_reg)
    );

    bit_addr_map #(.BIT_RAM_BASE(BIT_RAM_BASE)) u_bit (
        .bit_addr (op_addr),
        .loc      (loc_bit)
    );

    byte_addr_map #(.UPPER_RAM_PRESENT(UPPER_RAM_PRESENT)) u_byte (
        .addr     (op_addr),
        .indirect (kind_in == OPK_INDIRECT),
        .upper_en (upper_ram_en),
        .loc      (loc_byte),
        .blocked  (byte_blocked)
    );

    always_comb begin
        case (kind_in)
            OPK_REG: loc_sel = loc_reg;
            OPK_BIT: loc_sel = loc_bit;
            default: loc_sel = loc_byte;
        endcase
        req_d.vld     = in_vld;
        req_d.kind    = kind_in;
        req_d.op      = op_in;
        req_d.loc     = loc_sel;
        req_d.blocked = (kind_in == OPK_INDIRECT) && byte_blocked;
        req_d.wval    = wr_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (in_vld) begin
            req_q <= req_d;
        end else begin
            req_q.vld <= 1'b0;
        end
    end

    bit_rmw_unit u_rmw (
        .req     (req_q),
        .rd_byte (rd_byte),
        .wr_mask (wr_mask),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .bit_rd  (bit_rd)
    );

    always_comb begin
        out_vld        = req_q.vld;
        tgt_sfr        = (req_q.loc.tgt == TGT_SFR);
        byte_addr      = req_q.loc.addr;
        bit_idx        = req_q.loc.idx;
        access_blocked = req_q.vld && req_q.blocked;
    end

    AST_REG_IN_BANKS: assert property (@(posedge clk) disable iff (rst)
        (out_vld && req_q.kind == OPK_REG) |-> (!tgt_sfr && int'(byte_addr) < BANK_TOP)); // R1
    AST_BIT_RAM_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (out_vld && req_q.kind == OPK_BIT && !tgt_sfr) |->
            (byte_addr >= BIT_RAM_BASE && byte_addr <= BIT_RAM_LAST)); // R2
    AST_SFR_BIT_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (out_vld && req_q.kind == OPK_BIT && tgt_sfr) |-> (byte_addr[2:0] == 3'd0 && byte_addr[7])); // R3
    AST_INDIRECT_IN_RAM: assert property (@(posedge clk) disable iff (rst)
        (out_vld && req_q.kind == OPK_INDIRECT) |-> !tgt_sfr); // R5
    AST_BLOCKED_SILENT: assert property (@(posedge clk) disable iff (rst)
        access_blocked |-> (wr_mask == 8'h00 && rd_data == 8'h00 && !bit_rd)); // R6
    AST_BIT_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        (out_vld && req_q.kind == OPK_BIT) |-> $onehot0(wr_mask)); // R7
    AST_KEEP_OTHER_BITS: assert property (@(posedge clk) disable iff (rst)
        (((wr_data ^ rd_byte) & ~wr_mask) == 8'h00)); // R7
    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld); // R10
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> (wr_mask == 8'h00)); // R11
endmodule

// File: tb/tb_operand_resolver.sv
module tb_operand_resolver;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_vld;
    logic [1:0] op_kind, acc_op, bank_sel;
    logic [2:0] reg_num;
    logic [7:0] op_addr, wr_val, rd_byte;
    logic       upper_ram_en;
    logic       out_vld, tgt_sfr, bit_rd, access_blocked;
    logic [7:0] byte_addr, wr_mask, wr_data, rd_data;
    logic [2:0] bit_idx;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    operand_resolver dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .op_kind(op_kind), .acc_op(acc_op),
        .reg_num(reg_num), .op_addr(op_addr), .bank_sel(bank_sel),
        .upper_ram_en(upper_ram_en), .wr_val(wr_val), .rd_byte(rd_byte),
        .out_vld(out_vld), .tgt_sfr(tgt_sfr), .byte_addr(byte_addr), .bit_idx(bit_idx),
        .wr_mask(wr_mask), .wr_data(wr_data), .rd_data(rd_data), .bit_rd(bit_rd),
        .access_blocked(access_blocked)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive one request at a falling edge, let it be captured, sample at the next falling edge.
    task automatic issue(input logic [1:0] k, input logic [1:0] op, input logic [2:0] r,
                         input logic [7:0] a, input logic [1:0] b, input logic [7:0] wv,
                         input logic [7:0] rb, input logic up);
        @(negedge clk);
        in_vld = 1'b1; op_kind = k; acc_op = op; reg_num = r; op_addr = a;
        bank_sel = b; wr_val = wv; rd_byte = rb; upper_ram_en = up;
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 out_vld after reset", int'(out_vld), 0);
        chk("R11 wr_mask after reset", int'(wr_mask), 0);
    endtask

    task automatic t_regs();
        for (int b = 0; b < 4; b++) begin
            for (int r = 0; r < 8; r += 7) begin
                issue(2'd0, 2'd1, 3'(r), 8'h00, 2'(b), 8'h5A, 8'h11, 1'b1);
                chk("R1 reg addr", int'(byte_addr), b * 8 + r);
                chk("R1 reg target", int'(tgt_sfr), 0);
                chk("R10 out_vld", int'(out_vld), 1);
                chk("R9 reg write mask", int'(wr_mask), 8'hFF);
                chk("R9 reg write data", int'(wr_data), 8'h5A);
            end
        end
    endtask

    task automatic t_bit_ram();
        issue(2'd3, 2'd0, 3'd0, 8'h00, 2'd0, 8'h00, 8'h01, 1'b1);
        chk("R2 bit 00 addr", int'(byte_addr), 8'h20);
        chk("R2 bit 00 idx", int'(bit_idx), 0);
        chk("R8 bit read", int'(bit_rd), 1);
        chk("R8 read mask", int'(wr_mask), 0);
        issue(2'd3, 2'd2, 3'd0, 8'h7F, 2'd0, 8'h00, 8'h00, 1'b1);
        chk("R2 bit 7F addr", int'(byte_addr), 8'h2F);
        chk("R2 bit 7F idx", int'(bit_idx), 7);
        chk("R7 set mask", int'(wr_mask), 8'h80);
        chk("R7 set data", int'(wr_data), 8'h80);
        issue(2'd3, 2'd2, 3'd0, 8'h35, 2'd0, 8'h00, 8'h0F, 1'b1);
        chk("R2 bit 35 addr", int'(byte_addr), 8'h26);
        chk("R7 set mid", int'(wr_data), 8'h2F);
        chk("R2 target", int'(tgt_sfr), 0);
    endtask

    task automatic t_bit_sfr();
        issue(2'd3, 2'd0, 3'd0, 8'hE3, 2'd0, 8'h00, 8'hF7, 1'b1);
        chk("R3 bit E3 addr", int'(byte_addr), 8'hE0);
        chk("R3 bit E3 idx", int'(bit_idx), 3);
        chk("R3 target", int'(tgt_sfr), 1);
        chk("R8 read zero bit", int'(bit_rd), 0);
        issue(2'd3, 2'd3, 3'd0, 8'h8F, 2'd0, 8'h00, 8'hFF, 1'b1);
        chk("R3 bit 8F addr", int'(byte_addr), 8'h88);
        chk("R7 clr mask", int'(wr_mask), 8'h80);
        chk("R7 clr data", int'(wr_data), 8'h7F);
        issue(2'd3, 2'd1, 3'd0, 8'hC8, 2'd0, 8'h01, 8'hA0, 1'b1);
        chk("R3 bit C8 addr", int'(byte_addr), 8'hC8);
        chk("R8 bit write 1", int'(wr_data), 8'hA1);
        issue(2'd3, 2'd1, 3'd0, 8'h85, 2'd0, 8'hFE, 8'hFF, 1'b1);
        chk("R8 bit write 0", int'(wr_data), 8'hDF);
        chk("R8 bit write mask", int'(wr_mask), 8'h20);
    endtask

    task automatic t_direct();
        issue(2'd1, 2'd0, 3'd0, 8'h7F, 2'd0, 8'h00, 8'h3C, 1'b1);
        chk("R4 direct 7F target", int'(tgt_sfr), 0);
        chk("R4 direct 7F addr", int'(byte_addr), 8'h7F);
        chk("R9 direct read data", int'(rd_data), 8'h3C);
        issue(2'd1, 2'd2, 3'd0, 8'h80, 2'd0, 8'h00, 8'h3C, 1'b1);
        chk("R4 direct 80 target", int'(tgt_sfr), 1);
        chk("R4 direct 80 addr", int'(byte_addr), 8'h80);
        chk("R9 set on byte ignored", int'(wr_mask), 0);
        issue(2'd1, 2'd3, 3'd0, 8'h45, 2'd0, 8'h00, 8'h3C, 1'b1);
        chk("R4 direct 45 target", int'(tgt_sfr), 0);
        chk("R9 clr on byte ignored", int'(wr_mask), 0);
    endtask

    task automatic t_indirect();
        issue(2'd2, 2'd1, 3'd0, 8'h90, 2'd0, 8'h77, 8'h12, 1'b1);
        chk("R5 indirect target", int'(tgt_sfr), 0);
        chk("R5 indirect addr", int'(byte_addr), 8'h90);
        chk("R6 enabled not blocked", int'(access_blocked), 0);
        chk("R6 enabled write mask", int'(wr_mask), 8'hFF);
        issue(2'd2, 2'd1, 3'd0, 8'h90, 2'd0, 8'h77, 8'h12, 1'b0);
        chk("R6 blocked flag", int'(access_blocked), 1);
        chk("R6 blocked write mask", int'(wr_mask), 0);
        chk("R6 blocked read data", int'(rd_data), 0);
        issue(2'd2, 2'd0, 3'd0, 8'h40, 2'd0, 8'h00, 8'h66, 1'b0);
        chk("R6 low half unaffected", int'(rd_data), 8'h66);
        chk("R5 low half target", int'(tgt_sfr), 0);
    endtask

    task automatic t_idle();
        issue(2'd1, 2'd1, 3'd0, 8'h10, 2'd0, 8'h55, 8'h00, 1'b1);
        @(negedge clk);
        chk("R10 out_vld drops", int'(out_vld), 0);
        chk("R10 idle write mask", int'(wr_mask), 0);
    endtask

    initial begin
        rst = 1'b1; in_vld = 1'b0; op_kind = 2'd0; acc_op = 2'd0; reg_num = 3'd0;
        op_addr = 8'h00; bank_sel = 2'd0; upper_ram_en = 1'b1; wr_val = 8'h00; rd_byte = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_bit_ram();
        t_bit_sfr();
        t_direct();
        t_indirect();
        t_idle();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule